// File: doc/BRIEF.md
# Timestamp-Ordered Event Release Queue

This block holds pending spike events until they are nearly due. Each event is a 24-bit word: a 9-bit target identifier and a 15-bit target time. Events arrive on a valid/ready input in any time order. They are kept in a binary min-heap inside a 64-slot register array that stands in for a dual-port memory. The heap is ordered on target time, so the slot at the root always holds the earliest event. Insertion sifts the new entry upward, one level per cycle. Removal sifts the refilled root downward, two cycles per level: one cycle reads both children and picks the smaller, the next compares it with the travelling entry and moves one of them.

A free-running 15-bit counter advances once per clock and serves as system time. The root is offered on a valid/ready output as soon as its target time, minus the current time and taken as a signed 15-bit quantity, is below a lead window. The lead window is a 5-bit code times 32 cycles. Events whose time has already passed are offered at once. An insertion that meets a release in the same cycle puts the new event straight into the root slot and sifts it down, so the two share one heap pass. All time comparisons are wrap-aware, provided the pending events span less than half the counter range.

Top module: `ts_release_queue`

## Requirements
- R1: The queue accepts up to 64 events. Each event is a 24-bit word: identifier in bits 23:15, target time in bits 14:0.
- R2: Every released event carries the smallest target time among the events pending in that cycle. Target times are compared as signed 15-bit differences from the current time.
- R3: An event is offered only while its target time minus the current time, taken as a signed 15-bit value, is less than `lead_code` times 32. With code 0, only events whose time has already passed are offered.
- R4: An event whose target time is already past is offered on the output without waiting, once the queue is idle.
- R5: When 64 events are pending and no release is accepted in the cycle, `in_ready` is low.
- R6: When no event is pending, `out_valid` is low.
- R7: When an event is being released (`out_valid` and `out_ready` high) and the queue is idle, `in_ready` is high. An insertion is then accepted in the same cycle, even when the queue is full.
- R8: While `out_valid` is high and `out_ready` is low, the offered event stays unchanged on the next cycle and `in_ready` is low. Operations are accepted only when the heap is idle; a removal takes two cycles per heap level.
- R9: `sys_time` is 0 in reset and grows by exactly one, modulo 2^15, on every clock edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one time tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An event is presented for insertion |
| in_ready | output | 1 | The insertion is accepted this cycle |
| in_id | input | 9 | Target identifier of the incoming event |
| in_ts | input | 15 | Target time of the incoming event |
| lead_code | input | 5 | Lead window in units of 32 cycles |
| out_valid | output | 1 | The root event is due and offered |
| out_ready | input | 1 | The consumer takes the offered event |
| out_id | output | 9 | Identifier of the offered event |
| out_ts | output | 15 | Target time of the offered event |
| sys_time | output | 15 | Free-running system time |

## Verification
An insertion and a release can fall in the same cycle and then share one root-replacement pass. That pass must still leave the true minimum at the root. The bench provokes this by filling the queue with events that are not yet due, then opening the lead window. It presents a new event in exactly the cycle the first release is taken, and checks that both handshakes complete. Random traffic then keeps `out_ready` high most of the time so that such overlaps recur. Every release is judged against a pending-set model for the minimum target time and for the open window.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int TS_W = 15;
  localparam int ID_W = 9;

  typedef struct packed {
    logic [ID_W-1:0] id;
    logic [TS_W-1:0] ts;
  } evt_t;

  // a is strictly earlier than b on the wrapping time line
  function automatic logic earlier(input logic [TS_W-1:0] a, input logic [TS_W-1:0] b);
    logic [TS_W-1:0] d;
    d = a - b;
    return d[TS_W-1];
  endfunction

  // signed (ts - now) below the lead distance
  function automatic logic window_open(input logic [TS_W-1:0] ts, input logic [TS_W-1:0] now,
                                       input logic [TS_W-1:0] lead);
    logic [TS_W-1:0] d;
    d = ts - now;
    return $signed({d[TS_W-1], d}) < $signed({1'b0, lead});
  endfunction
endpackage

// File: rtl/tsq_clock.sv
module tsq_clock #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] now
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now <= '0;
    else        now <= now + 1'b1;
  end

  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> now == $past(now) + 1'b1); // R9
endmodule

// File: rtl/tsq_gate.sv
module tsq_gate
  import tsq_pkg::*;
#(
  parameter int LIM_W     = 5,
  parameter int LIM_SHIFT = 5
) (
  input  logic [TS_W-1:0]  root_ts,
  input  logic [TS_W-1:0]  now,
  input  logic [LIM_W-1:0] lim,
  output logic             due
);
  logic [TS_W-1:0] lead;
  assign lead = TS_W'(lim) << LIM_SHIFT;
  assign due  = window_open(root_ts, now, lead);
endmodule

// File: rtl/tsq_heap.sv
module tsq_heap
  import tsq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  evt_t                       din,
  output evt_t                       root,
  output logic [$clog2(DEPTH):0]     cnt,
  output logic                       idle
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;

  typedef enum logic [1:0] {S_IDLE, S_UP, S_PICK, S_MOVE} st_t;

  evt_t          mem [DEPTH];
  st_t           st;
  logic [IW-1:0] pos, cpos;
  evt_t          hold, cval;

  logic [CW-1:0] lidx;
  logic [CW:0]   ridx;
  logic [IW-1:0] par;
  logic          l_ok, r_ok, pick_r, up_swap, dn_swap;
  evt_t          lval, rval, pval;

  assign lidx    = {pos, 1'b1};
  assign ridx    = {1'b0, pos, 1'b1} + 1'b1;
  assign par     = (pos - 1'b1) >> 1;
  assign l_ok    = lidx < cnt;
  assign r_ok    = ridx < {1'b0, cnt};
  assign lval    = mem[lidx[IW-1:0]];
  assign rval    = mem[ridx[IW-1:0]];
  assign pval    = mem[par];
  assign pick_r  = r_ok && earlier(rval.ts, lval.ts);
  assign up_swap = (pos != '0) && earlier(hold.ts, pval.ts);
  assign dn_swap = earlier(cval.ts, hold.ts);

  // single write port
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  evt_t          wr_dat;

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = pos;
    wr_dat = hold;
    case (st)
      S_UP:   begin wr_en = 1'b1; if (up_swap) wr_dat = pval; end
      S_PICK: wr_en = !l_ok;
      S_MOVE: begin wr_en = 1'b1; if (dn_swap) wr_dat = cval; end
      default: wr_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_dat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pos  <= '0;
      cpos <= '0;
      hold <= '0;
      cval <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (push && pop) begin
            hold <= din;
            pos  <= '0;
            st   <= S_PICK;
          end else if (pop) begin
            cnt <= cnt - 1'b1;
            if (cnt != CW'(1)) begin
              hold <= mem[IW'(cnt - 1'b1)];
              pos  <= '0;
              st   <= S_PICK;
            end
          end else if (push) begin
            hold <= din;
            pos  <= cnt[IW-1:0];
            cnt  <= cnt + 1'b1;
            st   <= S_UP;
          end
        end
        S_UP: begin
          if (up_swap) pos <= par;
          else         st  <= S_IDLE;
        end
        S_PICK: begin
          if (!l_ok) st <= S_IDLE;
          else begin
            cpos <= pick_r ? ridx[IW-1:0] : lidx[IW-1:0];
            cval <= pick_r ? rval : lval;
            st   <= S_MOVE;
          end
        end
        S_MOVE: begin
          if (dn_swap) begin
            pos <= cpos;
            st  <= S_PICK;
          end else st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign root = mem[0];
  assign idle = (st == S_IDLE);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R1
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && !pop) |-> !push); // R5
  AST_ROOT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cnt > CW'(1)) |-> !earlier(mem[1].ts, mem[0].ts)); // R2
  AST_ROOT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cnt > CW'(2)) |-> !earlier(mem[2].ts, mem[0].ts)); // R2
  AST_OPS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (push || pop) |-> idle); // R8
  AST_PICK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MOVE) |-> cpos > pos); // R8
endmodule

// File: rtl/ts_release_queue.sv
module ts_release_queue
  import tsq_pkg::*;
#(
  parameter int DEPTH     = 64,
  parameter int LIM_W     = 5,
  parameter int LIM_SHIFT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ID_W-1:0]  in_id,
  input  logic [TS_W-1:0]  in_ts,
  input  logic [LIM_W-1:0] lead_code,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ID_W-1:0]  out_id,
  output logic [TS_W-1:0]  out_ts,
  output logic [TS_W-1:0]  sys_time
);
  localparam int CW = $clog2(DEPTH) + 1;

  evt_t          root, din;
  logic [CW-1:0] cnt;
  logic          idle, due, push, pop;

  assign din = '{id: in_id, ts: in_ts};

  tsq_clock #(.W(TS_W)) u_clock (
    .clk(clk), .rst_n(rst_n), .now(sys_time)
  );

  tsq_gate #(.LIM_W(LIM_W), .LIM_SHIFT(LIM_SHIFT)) u_gate (
    .root_ts(root.ts), .now(sys_time), .lim(lead_code), .due(due)
  );

  tsq_heap #(.DEPTH(DEPTH)) u_heap (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .din(din),
    .root(root), .cnt(cnt), .idle(idle)
  );

  assign out_valid = idle && (cnt != '0) && due;
  assign in_ready  = idle && (out_valid ? out_ready : (cnt < CW'(DEPTH)));
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_id    = root.id;
  assign out_ts    = root.ts;

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !out_valid); // R6
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_id) && $stable(out_ts))); // R8
  AST_STALL_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8
  AST_PAST_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cnt != '0 && earlier(root.ts, sys_time)) |-> out_valid); // R4
  AST_SHARED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready); // R7
endmodule

// File: tb/sim_ts_release_queue.sv
module sim_ts_release_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [8:0]  in_id = '0;
  logic [14:0] in_ts = '0;
  logic [4:0]  lead_code = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [8:0]  out_id;
  logic [14:0] out_ts;
  logic [14:0] sys_time;

  always #5 clk = ~clk;

  ts_release_queue u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_ts(in_ts), .lead_code(lead_code), .out_valid(out_valid),
    .out_ready(out_ready), .out_id(out_id), .out_ts(out_ts), .sys_time(sys_time)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [14:0] tb_time = '0;
  logic [14:0] m_ts [64];
  logic [8:0]  m_id [64];
  int          m_n = 0;
  bit          stalled = 0;
  logic [8:0]  st_id;
  logic [14:0] st_ts;

  always @(posedge clk) begin
    if (!rst_n) tb_time <= '0;
    else        tb_time <= tb_time + 15'd1;
  end

  function automatic int sdiff(input logic [14:0] a, input logic [14:0] b);
    logic [14:0] d;
    d = a - b;
    return int'($signed(d));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0d", req, act, exp, tb_time);
    end
  endtask

  // one cycle: drive at negedge, judge after settling, update model
  task automatic cycle(input bit iv, input logic [8:0] id, input logic [14:0] ts,
                       input bit ordy, output bit acc);
    int best;
    int hit;
    @(negedge clk);
    in_valid = iv; in_id = id; in_ts = ts; out_ready = ordy;
    #1;
    chk(sys_time == tb_time, "R9 time", sys_time, tb_time);
    if (stalled) begin
      chk(out_valid && out_id == st_id && out_ts == st_ts, "R8 hold", out_ts, st_ts);
    end
    if (out_valid && !out_ready) chk(!in_ready, "R8 in blocked", in_ready, 0);
    if (m_n == 0) chk(!out_valid, "R6 empty", out_valid, 0);
    if (m_n == 64 && !(out_valid && out_ready)) chk(!in_ready, "R5 full", in_ready, 0);
    stalled = out_valid && !out_ready;
    st_id = out_id; st_ts = out_ts;
    acc = iv && in_ready;
    if (out_valid && out_ready) begin
      best = 0;
      for (int k = 1; k < m_n; k++)
        if (sdiff(m_ts[k], tb_time) < sdiff(m_ts[best], tb_time)) best = k;
      if (m_n > 0) chk(out_ts == m_ts[best], "R2 minimum", out_ts, m_ts[best]);
      else chk(0, "R2 release from empty", 1, 0);
      chk(sdiff(out_ts, tb_time) < int'(lead_code) * 32, "R3 window",
          sdiff(out_ts, tb_time), int'(lead_code) * 32);
      hit = -1;
      for (int k = 0; k < m_n; k++)
        if (hit < 0 && m_ts[k] == out_ts && m_id[k] == out_id) hit = k;
      chk(hit >= 0, "R2 event known", out_id, 0);
      if (hit >= 0) begin
        m_ts[hit] = m_ts[m_n-1]; m_id[hit] = m_id[m_n-1]; m_n--;
      end
    end
    if (acc) begin
      m_ts[m_n] = ts; m_id[m_n] = id; m_n++;
    end
  endtask

  task automatic idle_cycles(input int n, input bit ordy);
    bit a;
    for (int i = 0; i < n; i++) cycle(0, '0, '0, ordy, a);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit a;
    int guard;
    bit both;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk(!out_valid, "R6 reset", out_valid, 0);
    chk(in_ready, "R1 ready after reset", in_ready, 1);
    chk(sys_time == 0, "R9 reset", sys_time, 0);
    rst_n = 1'b1;

    // R4: an overdue event is offered with lead 0, and R8 holds it while stalled
    lead_code = 5'd0;
    cycle(1, 9'h15, tb_time - 15'd50, 0, a);
    chk(a, "R1 accept", a, 1);
    idle_cycles(4, 0);
    chk(out_valid && out_id == 9'h15, "R4 overdue offered", out_valid, 1);
    cycle(0, '0, '0, 1, a);

    // R1/R5: fill to 64 with future events
    for (int k = 0; k < 64; k++) begin
      guard = 0;
      a = 0;
      while (!a && guard < 30) begin
        cycle(1, 9'(k), tb_time + 15'd2600 + 15'(k * 7), 1, a);
        guard++;
      end
      chk(a, "R1 fill accept", k, k);
    end
    chk(m_n == 64, "R1 count", m_n, 64);
    cycle(1, 9'h1ff, tb_time, 1, a);
    chk(!a, "R5 full stall", a, 0);
    chk(!out_valid, "R3 window closed", out_valid, 0);

    // R7: open the window, insert in the cycle of the first release
    lead_code = 5'd31;
    guard = 0;
    while (!out_valid && guard < 4000) begin
      idle_cycles(1, 0);
      guard++;
    end
    chk(out_valid, "R3 window opens", out_valid, 1);
    cycle(1, 9'h0aa, tb_time + 15'd2000, 1, a);
    both = a;
    chk(both, "R7 insert with release", a, 1);
    chk(m_n == 64, "R7 count kept", m_n, 64);

    // drain
    guard = 0;
    while (m_n > 0 && guard < 6000) begin idle_cycles(1, 1); guard++; end
    chk(m_n == 0, "R2 drained", m_n, 0);
    idle_cycles(3, 1);
    chk(!out_valid, "R6 after drain", out_valid, 0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if (i % 500 == 0) lead_code = 5'($urandom_range(0, 31));
      cycle($urandom_range(0, 1), 9'($urandom_range(0, 511)),
            tb_time + 15'($urandom_range(0, 900)) - 15'd100,
            $urandom_range(0, 9) < 7, a);
    end
    guard = 0;
    while (m_n > 0 && guard < 8000) begin idle_cycles(1, 1); guard++; end
    chk(m_n == 0, "R2 random drained", m_n, 0);
    idle_cycles(3, 1);
    chk(!out_valid, "R6 final", out_valid, 0);
    finish_run();
  end
endmodule